// File: doc/BRIEF.md
# Memory Map Address Decoder with Boot Overlay

This block sits between the CPU of an 8-bit system and its memories. It takes a 16-bit address, works out which target that address belongs to, and turns a request into a write strobe or a read-data selection. The targets are cartridge ROM, a boot ROM overlay, video RAM, external RAM, work RAM and its echo window, sprite attribute RAM, high RAM, an interrupt-enable register, and two register ports that lead to the joypad and video units outside the block.

A request lasts one cycle. Writes take effect at the clock edge that samples the request. Read data is registered and appears one cycle after the request, together with a valid flag. The RAMs are small on-chip byte arrays, and each one has a parameterised depth. The two ROMs return contents computed from the address, which stand in for a loaded image. The block also holds the boot-overlay flag. Reset sets this flag, and a write to the boot-control address clears it for good.

Top module: `memMapDecoder`

## Requirements
- R1: A read in 0x0000–0x7FFF, other than an overlaid boot read, returns the cartridge byte `addr[7:0] ^ {1'b0, addr[14:8]}`.
- R2: While `bootActive` is 1, reads in 0x0000–0x00FF return the boot byte `addr[7:0] ^ 8'hA5`.
- R3: Reset sets `bootActive` to 1. A write of any value to 0xFF50 clears it, and it stays 0 until the next reset. That write is not forwarded to the video port.
- R4: Writes in 0x0000–0x7FFF leave every later read of ROM space unchanged.
- R5: Video RAM (0x8000–0x9FFF), external RAM (0xA000–0xBFFF) and work RAM (0xC000–0xDFFF) are separate read/write arrays. Each is indexed by the low log2(depth) bits of the address.
- R6: 0xE000–0xFDFF reaches work RAM through `addr[12:0]`, for both reads and writes.
- R7: 0xFE00–0xFE9F is a 160-byte sprite attribute RAM indexed by `addr[7:0]`. 0xFF80–0xFFFE is a 127-byte high RAM indexed by `addr[6:0]`.
- R8: 0xFFFF is an 8-bit interrupt-enable register that can be read and written. It resets to 0x00.
- R9: 0xFF00 drives `padSel` and 0xFF40–0xFF7F drives `vidSel`. Both are combinational during the request. `ioAddr = addr[6:0]`, `ioWdata` carries the write data, and `ioWrite` marks a write. Reads return `padRdata` or `vidRdata` as sampled in the request cycle.
- R10: Reads of 0xFEA0–0xFEFF and 0xFF01–0xFF3F return 0xFF. Writes there change nothing. Either kind of request raises `ioErr` for exactly the one cycle after the request.
- R11: After a read request, `rdValid` is 1 and `rdData` is valid in the following cycle. Write requests never raise `rdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | CPU address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | Read data valid (one cycle after a read) |
| rdData | output | 8 | Registered read data |
| bootActive | output | 1 | Boot overlay flag |
| ioErr | output | 1 | One-cycle pulse after an unmapped access |
| padSel | output | 1 | Joypad register port select |
| vidSel | output | 1 | Video register port select |
| ioWrite | output | 1 | Register port write qualifier |
| ioAddr | output | 7 | Register port offset |
| ioWdata | output | 8 | Register port write data |
| padRdata | input | 8 | Joypad register read data |
| vidRdata | input | 8 | Video register read data |

## Verification
The assertions assume that reset is held low at time zero and that `reqWrite`, `reqAddr` and `reqWdata` are stable and known whenever `reqValid` is 1. They also assume that `padRdata` and `vidRdata` settle within the request cycle. The stimulus changes inputs only at falling edges and drops `reqValid` between requests. The video read data is a pure function of `ioAddr`. The sweeps cover every RAM offset, every address in each unmapped window and each boot-flag transition, and expected bytes come from the address formulas above.

// File: rtl/memMapPkg.sv
package memMapPkg;

  typedef enum logic [3:0] {
    RG_BOOT, RG_ROM, RG_VRAM, RG_ERAM, RG_WRAM,
    RG_OAM, RG_HRAM, RG_IE, RG_PAD, RG_VID, RG_NONE
  } regionE;

  typedef struct packed {
    logic   rdEn;
    logic   vramWe;
    logic   eramWe;
    logic   wramWe;
    logic   oamWe;
    logic   hramWe;
    logic   ieWe;
    regionE rdSel;
  } strobeT;

  function automatic logic [7:0] bootByte(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  function automatic logic [7:0] romByte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

endpackage

// File: rtl/byteRam.sv
module byteRam #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  logic       inRange;

  assign inRange = int'(addr) < DEPTH;

  always_ff @(posedge clk) begin
    if (we && inRange) mem[addr] <= wdata;
  end

  assign rdata = inRange ? mem[addr] : 8'h00;
endmodule

// File: rtl/mapCtrl.sv
module mapCtrl
  import memMapPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  output strobeT      strobe,
  output logic        bootActive,
  output logic        ioErr,
  output logic        padSel,
  output logic        vidSel,
  output logic        ioWrite
);
  localparam logic [15:0] BOOT_CTL_ADDR = 16'hFF50;

  regionE region;
  logic   bootFlag;
  logic   wrReq;
  logic   bootCtlWr;

  // region decode: upper nibble first, then the top page in detail
  always_comb begin
    region = RG_NONE;
    unique case (reqAddr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7:
        region = (bootFlag && reqAddr[15:8] == 8'h00) ? RG_BOOT : RG_ROM;
      4'h8, 4'h9: region = RG_VRAM;
      4'hA, 4'hB: region = RG_ERAM;
      4'hC, 4'hD, 4'hE: region = RG_WRAM;
      4'hF: begin
        if (reqAddr[11:9] != 3'b111)        region = RG_WRAM;
        else if (!reqAddr[8])               region = (reqAddr[7:0] < 8'hA0) ? RG_OAM : RG_NONE;
        else if (reqAddr[7:0] == 8'hFF)     region = RG_IE;
        else if (reqAddr[7])                region = RG_HRAM;
        else if (reqAddr[7:0] == 8'h00)     region = RG_PAD;
        else if (reqAddr[6])                region = RG_VID;
        else                                region = RG_NONE;
      end
      default: region = RG_NONE;
    endcase
  end

  assign wrReq     = reqValid && reqWrite;
  assign bootCtlWr = wrReq && (reqAddr == BOOT_CTL_ADDR);

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = reqValid && !reqWrite;
    strobe.vramWe = wrReq && region == RG_VRAM;
    strobe.eramWe = wrReq && region == RG_ERAM;
    strobe.wramWe = wrReq && region == RG_WRAM;
    strobe.oamWe  = wrReq && region == RG_OAM;
    strobe.hramWe = wrReq && region == RG_HRAM;
    strobe.ieWe   = wrReq && region == RG_IE;
    strobe.rdSel  = region;
  end

  assign padSel  = reqValid && region == RG_PAD;
  assign vidSel  = reqValid && region == RG_VID && !bootCtlWr;
  assign ioWrite = wrReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootFlag <= 1'b1;
      ioErr    <= 1'b0;
    end else begin
      if (bootCtlWr) bootFlag <= 1'b0;
      ioErr <= reqValid && region == RG_NONE;
    end
  end

  assign bootActive = bootFlag;

  assert_boot_no_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(bootFlag));

  assert_boot_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    bootCtlWr |=> !bootFlag);

  assert_err_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && region == RG_NONE) |=> ioErr);

  assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({padSel, vidSel}));
endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import memMapPkg::*;
#(
  parameter int VRAM_DEPTH = 64,
  parameter int ERAM_DEPTH = 64,
  parameter int WRAM_DEPTH = 64,
  parameter int OAM_DEPTH  = 160,
  parameter int HRAM_DEPTH = 127
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      strobe,
  input  logic [14:0] addr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  padRdata,
  input  logic [7:0]  vidRdata,
  output logic        rdValid,
  output logic [7:0]  rdData
);
  localparam int VRAM_AW = $clog2(VRAM_DEPTH);
  localparam int ERAM_AW = $clog2(ERAM_DEPTH);
  localparam int WRAM_AW = $clog2(WRAM_DEPTH);
  localparam int OAM_AW  = $clog2(OAM_DEPTH);
  localparam int HRAM_AW = $clog2(HRAM_DEPTH);

  logic [7:0] vramQ, eramQ, wramQ, oamQ, hramQ;
  logic [7:0] ieReg;
  logic [7:0] rdMux;

  byteRam #(.DEPTH(VRAM_DEPTH)) u_vram (
    .clk(clk), .we(strobe.vramWe), .addr(addr[VRAM_AW-1:0]), .wdata(wdata), .rdata(vramQ));
  byteRam #(.DEPTH(ERAM_DEPTH)) u_eram (
    .clk(clk), .we(strobe.eramWe), .addr(addr[ERAM_AW-1:0]), .wdata(wdata), .rdata(eramQ));
  byteRam #(.DEPTH(WRAM_DEPTH)) u_wram (
    .clk(clk), .we(strobe.wramWe), .addr(addr[WRAM_AW-1:0]), .wdata(wdata), .rdata(wramQ));
  byteRam #(.DEPTH(OAM_DEPTH)) u_oam (
    .clk(clk), .we(strobe.oamWe), .addr(addr[OAM_AW-1:0]), .wdata(wdata), .rdata(oamQ));
  byteRam #(.DEPTH(HRAM_DEPTH)) u_hram (
    .clk(clk), .we(strobe.hramWe), .addr(addr[HRAM_AW-1:0]), .wdata(wdata), .rdata(hramQ));

  always_ff @(posedge clk) begin
    if (!rstN)             ieReg <= 8'h00;
    else if (strobe.ieWe)  ieReg <= wdata;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RG_BOOT: rdMux = bootByte(addr[7:0]);
      RG_ROM:  rdMux = romByte(addr);
      RG_VRAM: rdMux = vramQ;
      RG_ERAM: rdMux = eramQ;
      RG_WRAM: rdMux = wramQ;
      RG_OAM:  rdMux = oamQ;
      RG_HRAM: rdMux = hramQ;
      RG_IE:   rdMux = ieReg;
      RG_PAD:  rdMux = padRdata;
      RG_VID:  rdMux = vidRdata;
      default: rdMux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 8'h00;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdMux;
    end
  end

  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strobe.rdEn));

  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.vramWe, strobe.eramWe, strobe.wramWe,
              strobe.oamWe, strobe.hramWe, strobe.ieWe}));

  assert_ie_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ieWe |=> ieReg == $past(wdata));
endmodule

// File: rtl/memMapDecoder.sv
module memMapDecoder
  import memMapPkg::*;
#(
  parameter int VRAM_DEPTH = 64,
  parameter int ERAM_DEPTH = 64,
  parameter int WRAM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWdata,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        bootActive,
  output logic        ioErr,
  output logic        padSel,
  output logic        vidSel,
  output logic        ioWrite,
  output logic [6:0]  ioAddr,
  output logic [7:0]  ioWdata,
  input  logic [7:0]  padRdata,
  input  logic [7:0]  vidRdata
);
  strobeT strobe;

  mapCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .strobe(strobe), .bootActive(bootActive),
    .ioErr(ioErr), .padSel(padSel), .vidSel(vidSel), .ioWrite(ioWrite));

  mapDatapath #(
    .VRAM_DEPTH(VRAM_DEPTH), .ERAM_DEPTH(ERAM_DEPTH), .WRAM_DEPTH(WRAM_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(reqAddr[14:0]),
    .wdata(reqWdata), .padRdata(padRdata), .vidRdata(vidRdata),
    .rdValid(rdValid), .rdData(rdData));

  assign ioAddr  = reqAddr[6:0];
  assign ioWdata = reqWdata;

  assert_err_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ioErr && rdValid) |-> rdData == 8'hFF);
endmodule

// File: tb/memMapDecoder_tb.sv
`timescale 1ns/1ps
module memMapDecoder_tb;
  localparam int RAM_DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic rdValid, bootActive, ioErr, padSel, vidSel, ioWrite;
  logic [7:0] rdData, ioWdata;
  logic [6:0] ioAddr;
  logic [7:0] padRdata = 8'hC5;
  logic [7:0] vidRdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic obsPad, obsVid, obsIoW, obsErr, obsRdv;
  logic [6:0] obsIoAddr;
  logic [7:0] obsIoWdata, lastRd;

  always #2 clk = ~clk;
  assign vidRdata = {1'b0, ioAddr} ^ 8'h3C;

  memMapDecoder u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData),
    .bootActive(bootActive), .ioErr(ioErr), .padSel(padSel), .vidSel(vidSel),
    .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .padRdata(padRdata), .vidRdata(vidRdata));

  function automatic logic [7:0] romExp(input logic [15:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    #1;
    obsPad = padSel; obsVid = vidSel; obsIoW = ioWrite;
    obsIoAddr = ioAddr; obsIoWdata = ioWdata;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
    obsErr = ioErr; obsRdv = rdValid;
  endtask

  task automatic rdOnly(input logic [15:0] a);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    #1;
    obsPad = padSel; obsVid = vidSel; obsIoAddr = ioAddr;
    @(negedge clk);
    reqValid = 0;
    obsErr = ioErr; obsRdv = rdValid; lastRd = rdData;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    rdOnly(a);
    chk(obsRdv === 1'b1 && lastRd === exp, req, {a[7:0], lastRd}, {a[7:0], exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state: R3 R8 R11
    chk(bootActive === 1'b1, "R3 reset flag", 16'(bootActive), 16'd1);
    chk(rdValid === 1'b0 && ioErr === 1'b0, "R11 reset idle", {rdValid, ioErr}, 16'd0);
    rstN = 1;
    rd(16'hFFFF, 8'h00, "R8 ie reset");

    // R2 boot overlay over whole low page
    for (int i = 0; i < 256; i++) rd(16'(i), 8'(i) ^ 8'hA5, "R2 boot read");
    rd(16'h0100, romExp(16'h0100), "R1 first cart byte above overlay");

    // R1 cartridge sweep
    for (int a = 16'h0100; a < 16'h8000; a += 37) rd(16'(a), romExp(16'(a)), "R1 cart read");

    // R4 ROM writes ignored
    wr(16'h1234, 8'h00);
    chk(obsRdv === 1'b0, "R11 write gives no rdValid", 16'(obsRdv), 16'd0);
    rd(16'h1234, romExp(16'h1234), "R4 rom after write");
    wr(16'h0010, 8'hFF);
    rd(16'h0010, 8'h10 ^ 8'hA5, "R4 boot after write");
    wr(16'h7FFF, 8'h00);
    rd(16'h7FFF, romExp(16'h7FFF), "R4 rom top after write");

    // R5 three independent arrays
    for (int i = 0; i < RAM_DEPTH; i++) begin
      wr(16'h8000 + 16'(i), 8'(i * 3 + 1));
      wr(16'hA000 + 16'(i), 8'(i * 5 + 2));
      wr(16'hC000 + 16'(i), 8'(i * 7 + 3));
    end
    for (int i = 0; i < RAM_DEPTH; i++) begin
      rd(16'h8000 + 16'(i), 8'(i * 3 + 1), "R5 vram");
      rd(16'hA000 + 16'(i), 8'(i * 5 + 2), "R5 eram");
      rd(16'hC000 + 16'(i), 8'(i * 7 + 3), "R5 wram");
      rd(16'h9FC0 + 16'(i), 8'(i * 3 + 1), "R5 vram low-bit index");
    end

    // R6 echo window both directions
    for (int i = 0; i < RAM_DEPTH; i++) wr(16'hE000 + 16'(i), 8'(i) ^ 8'h99);
    for (int i = 0; i < RAM_DEPTH; i++) rd(16'hC000 + 16'(i), 8'(i) ^ 8'h99, "R6 echo write");
    for (int i = 0; i < RAM_DEPTH; i++) wr(16'hD000 + 16'(i), 8'(i) ^ 8'h66);
    for (int i = 0; i < RAM_DEPTH; i++) rd(16'hFD00 + 16'(i), 8'(i) ^ 8'h66, "R6 echo read");

    // R7 sprite attribute RAM and high RAM
    for (int i = 0; i < 160; i++) wr(16'hFE00 + 16'(i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < 127; i++) wr(16'hFF80 + 16'(i), 8'(i + 17));
    wr(16'hFFFF, 8'hA3);
    for (int i = 0; i < 160; i++) rd(16'hFE00 + 16'(i), 8'(i) ^ 8'h5A, "R7 oam");
    for (int i = 0; i < 127; i++) rd(16'hFF80 + 16'(i), 8'(i + 17), "R7 hram");
    rd(16'hFFFF, 8'hA3, "R8 ie readback");

    // R9 register ports
    rd(16'hFF00, 8'hC5, "R9 pad read");
    chk(obsPad === 1'b1 && obsVid === 1'b0, "R9 pad select on read", {obsPad, obsVid}, 16'b10);
    wr(16'hFF00, 8'h30);
    chk(obsPad === 1'b1 && obsIoW === 1'b1 && obsIoAddr === 7'h00 && obsIoWdata === 8'h30,
        "R9 pad write", {obsPad, obsIoW, obsIoWdata}, {2'b11, 8'h30});
    for (int a = 16'hFF40; a < 16'hFF80; a++) begin
      rd(16'(a), {1'b0, a[6:0]} ^ 8'h3C, "R9 video read");
      chk(obsVid === 1'b1 && obsPad === 1'b0, "R9 video select", {obsVid, obsPad}, 16'b10);
    end
    wr(16'hFF42, 8'h77);
    chk(obsVid === 1'b1 && obsIoAddr === 7'h42 && obsIoWdata === 8'h77,
        "R9 video write", {obsVid, 1'b0, obsIoAddr}, {1'b1, 8'h42});

    // R10 unmapped windows
    for (int a = 16'hFEA0; a < 16'hFF00; a++) begin
      rd(16'(a), 8'hFF, "R10 unmapped read high oam page");
      chk(obsErr === 1'b1, "R10 error pulse", 16'(obsErr), 16'd1);
    end
    for (int a = 16'hFF01; a < 16'hFF40; a++) begin
      rd(16'(a), 8'hFF, "R10 unmapped read io page");
      chk(obsErr === 1'b1 && obsPad === 1'b0 && obsVid === 1'b0, "R10 unmapped no select",
          {obsErr, obsPad, obsVid}, 16'b100);
    end
    wr(16'hFEA0, 8'h00);
    chk(obsErr === 1'b1 && obsPad === 1'b0 && obsVid === 1'b0, "R10 unmapped write",
        {obsErr, obsPad, obsVid}, 16'b100);
    rd(16'hFE9F, 8'h9F ^ 8'h5A, "R10 oam untouched by unmapped write");
    chk(obsErr === 1'b0, "R10 pulse lasts one cycle", 16'(obsErr), 16'd0);
    wr(16'hFF0F, 8'h00);
    rd(16'hFFFF, 8'hA3, "R10 ie untouched by unmapped write");

    // R3 boot control
    wr(16'hFF50, 8'h00);
    chk(obsVid === 1'b0, "R3 boot write not forwarded", 16'(obsVid), 16'd0);
    chk(bootActive === 1'b0, "R3 flag cleared", 16'(bootActive), 16'd0);
    for (int i = 0; i < 256; i++) rd(16'(i), romExp(16'(i)), "R3 cart visible after clear");
    rd(16'hFF50, 8'h50 ^ 8'h3C, "R9 boot-control read goes to video port");
    chk(bootActive === 1'b0, "R3 flag stays clear", 16'(bootActive), 16'd0);
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk);
    chk(bootActive === 1'b1, "R3 reset sets flag", 16'(bootActive), 16'd1);
    rstN = 1;
    rd(16'h0003, 8'h03 ^ 8'hA5, "R3 overlay back after reset");
    rd(16'hFFFF, 8'h00, "R8 ie cleared by reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule